// File: doc/BRIEF.md
# Beam-Locked Display List Sequencer

This block runs a short byte-coded program out of a local list RAM in step with the video beam. The program can hold execution until a given raster line and cycle. It can write a value into one of the video chip's registers, jump by a relative offset, and load or count down two loop counters. When a counter is already zero, the count-down instruction skips the following two list bytes. This lets a program built from a body and a backward jump repeat a fixed number of times.

The sequencer reads its list through a synchronous read port with one clock of latency. It executes at most one instruction in any one beam cycle. A one-clock `frame_start` pulse restarts the program from list address 0. A wait for the position (511, 63) can never be met, so it serves as the end of the program and raises `halted`.

Top module: `beam_list_engine`

## Requirements
- R1: A wait instruction has a first byte of the form 1LLLLLLL and a second byte of the form LLCCCCCC. Together they give a 9-bit line (the high seven bits come first) and a 6-bit cycle. Execution holds until `beam_line` and `beam_cycle` both equal the target. The next instruction can then run in that same beam cycle.
- R2: A register write has a first byte of the form 01RRRRRR and a second byte holding the data. It produces exactly one `wr_strobe` pulse, one clock wide, with `wr_reg` set to RRRRRR and `wr_data` set to the data. Two writes in a row give two separate pulses.
- R3: The bytes 0xFF, 0xFF form a wait for (511, 63). That position is never reached, so `halted` goes high and stays high with no further writes until the next `frame_start`.
- R4: A branch is 0x00 followed by a signed 8-bit offset, added to the address of the next instruction. An offset of -2 loops on itself and produces no writes.
- R5: 0x01 n loads counter A with n, and 0x02 n loads counter B with n.
- R6: 0x03 acts on counter A and 0x04 acts on counter B, each as a one-byte instruction. If the counter is zero, the next two list bytes are skipped. Otherwise the counter drops by one and execution goes on with the next byte.
- R7: A `frame_start` pulse puts the program address back to 0 and clears `halted`. The first instruction then executes within the same beam cycle.
- R8: A wait for a position that has already passed in the current frame is never satisfied later in that frame. Nothing after it executes.
- R9: Every instruction other than a wait takes up one beam cycle. A second such instruction waits until `beam_cycle` changes.
- R10: After reset, `wr_strobe` and `halted` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at least four per beam cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-clock pulse at line 0, cycle 0 |
| beam_line | input | 9 | Current raster line |
| beam_cycle | input | 6 | Current cycle within the line |
| ram_addr | output | AW | List RAM read address |
| ram_data | input | 8 | List RAM read data, one clock after the address |
| wr_strobe | output | 1 | One-clock register write pulse |
| wr_reg | output | 6 | Register index of the write |
| wr_data | output | 8 | Data of the write |
| halted | output | 1 | Held at the end-of-program wait |

## Verification
The bench records the beam position of every write and compares it with the cycle the program should reach. A counted loop that ran one pass too many or too few, or that decremented a counter it should have skipped on, would shift or add entries in that log.

A skip of one or three bytes instead of two would land in the middle of an instruction and write garbage. So would a branch measured from the wrong address. A wait compared with greater-or-equal instead of equality would fire on a position already passed and let a forbidden write through. Missing one-per-beam-cycle gating would squeeze the loop writes together. Finally, a restart that left the old address in place would lose the write at the start of the frame.

// File: rtl/dl_pkg.sv
`timescale 1ns/1ps
package dl_pkg;
    localparam int LINE_W = 9;
    localparam int CYC_W  = 6;
    localparam int REG_W  = 6;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {ST_FETCH, ST_OP, ST_ARG} seq_st_e;

    typedef enum logic [2:0] {
        K_WAIT, K_MOV, K_BRA, K_SETA, K_SETB, K_DECA, K_DECB, K_NOP
    } op_kind_e;

    localparam logic [7:0] OPC_BRA  = 8'h00;
    localparam logic [7:0] OPC_SETA = 8'h01;
    localparam logic [7:0] OPC_SETB = 8'h02;
    localparam logic [7:0] OPC_DECA = 8'h03;
    localparam logic [7:0] OPC_DECB = 8'h04;
endpackage

// File: rtl/dl_decode.sv
`timescale 1ns/1ps
module dl_decode
    import dl_pkg::*;
(
    input  logic [BYTE_W-1:0] op_byte,
    output op_kind_e          kind
);
    always_comb begin
        if (op_byte[7])
            kind = K_WAIT;
        else if (op_byte[6])
            kind = K_MOV;
        else begin
            unique case (op_byte)
                OPC_BRA:  kind = K_BRA;
                OPC_SETA: kind = K_SETA;
                OPC_SETB: kind = K_SETB;
                OPC_DECA: kind = K_DECA;
                OPC_DECB: kind = K_DECB;
                default:  kind = K_NOP;
            endcase
        end
    end
endmodule

// File: rtl/dl_loop_ctr.sv
`timescale 1ns/1ps
module dl_loop_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/dl_beat_gate.sv
`timescale 1ns/1ps
module dl_beat_gate #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          consume,
    input  logic [CW-1:0] beam_cycle,
    output logic          beat_ok
);
    logic          spent_d, spent_q;
    logic [CW-1:0] cyc_d, cyc_q;

    assign beat_ok = !spent_q || (beam_cycle != cyc_q);

    always_comb begin
        spent_d = spent_q;
        cyc_d   = cyc_q;
        if (clear)
            spent_d = 1'b0;
        else if (consume) begin
            spent_d = 1'b1;
            cyc_d   = beam_cycle;
        end else if (beam_cycle != cyc_q)
            spent_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spent_q <= 1'b0;
            cyc_q   <= '0;
        end else begin
            spent_q <= spent_d;
            cyc_q   <= cyc_d;
        end
    end
endmodule

// File: rtl/beam_list_engine.sv
`timescale 1ns/1ps
module beam_list_engine
    import dl_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [LINE_W-1:0] beam_line,
    input  logic [CYC_W-1:0]  beam_cycle,
    output logic [AW-1:0]     ram_addr,
    input  logic [BYTE_W-1:0] ram_data,
    output logic              wr_strobe,
    output logic [REG_W-1:0]  wr_reg,
    output logic [BYTE_W-1:0] wr_data,
    output logic              halted
);
    localparam int NCTR = 2;

    typedef struct packed {
        seq_st_e           st;
        logic [AW-1:0]     pc;
        logic [BYTE_W-1:0] op;
        logic              strobe;
        logic [REG_W-1:0]  rg;
        logic [BYTE_W-1:0] data;
    } seq_t;

    seq_t q, d;

    op_kind_e          kind;
    logic              beat_ok, consume;
    logic [NCTR-1:0]   ld, dc, zero;
    logic [LINE_W-1:0] tgt_line;
    logic [CYC_W-1:0]  tgt_cyc;
    logic [AW-1:0]     pc1, pc2, pc3, br_tgt;

    dl_decode u_dec (.op_byte(q.op), .kind(kind));

    dl_beat_gate #(.CW(CYC_W)) u_beat (
        .clk(clk), .rst_n(rst_n), .clear(frame_start),
        .consume(consume), .beam_cycle(beam_cycle), .beat_ok(beat_ok)
    );

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        dl_loop_ctr #(.W(BYTE_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .load(ld[i]), .dec(dc[i]),
            .load_val(ram_data), .is_zero(zero[i])
        );
    end

    assign tgt_line = {q.op[6:0], ram_data[7:6]};
    assign tgt_cyc  = ram_data[5:0];
    assign pc1      = q.pc + AW'(1);
    assign pc2      = q.pc + AW'(2);
    assign pc3      = q.pc + AW'(3);
    assign br_tgt   = pc2 + {{(AW-BYTE_W){ram_data[7]}}, ram_data};

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        consume  = 1'b0;
        ld       = '0;
        dc       = '0;
        unique case (q.st)
            ST_FETCH: d.st = ST_OP;
            ST_OP: begin
                d.op = ram_data;
                d.st = ST_ARG;
            end
            ST_ARG: begin
                if (kind == K_WAIT) begin
                    if (beam_line == tgt_line && beam_cycle == tgt_cyc) begin
                        d.pc = pc2;
                        d.st = ST_FETCH;
                    end
                end else if (beat_ok) begin
                    consume = 1'b1;
                    d.st    = ST_FETCH;
                    unique case (kind)
                        K_MOV: begin
                            d.strobe = 1'b1;
                            d.rg     = q.op[REG_W-1:0];
                            d.data   = ram_data;
                            d.pc     = pc2;
                        end
                        K_BRA:  d.pc = br_tgt;
                        K_SETA: begin ld[0] = 1'b1; d.pc = pc2; end
                        K_SETB: begin ld[1] = 1'b1; d.pc = pc2; end
                        K_DECA: begin
                            if (zero[0]) d.pc = pc3;
                            else begin dc[0] = 1'b1; d.pc = pc1; end
                        end
                        K_DECB: begin
                            if (zero[1]) d.pc = pc3;
                            else begin dc[1] = 1'b1; d.pc = pc1; end
                        end
                        default: d.pc = pc1;
                    endcase
                end
            end
            default: d.st = ST_FETCH;
        endcase
        if (frame_start) begin
            d.st     = ST_FETCH;
            d.pc     = '0;
            d.strobe = 1'b0;
            consume  = 1'b0;
            ld       = '0;
            dc       = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_FETCH;
            q.pc     <= '0;
            q.op     <= '0;
            q.strobe <= 1'b0;
            q.rg     <= '0;
            q.data   <= '0;
        end else begin
            q <= d;
        end
    end

    assign ram_addr  = (q.st == ST_FETCH) ? q.pc : pc1;
    assign wr_strobe = q.strobe;
    assign wr_reg    = q.rg;
    assign wr_data   = q.data;
    assign halted    = (q.st == ST_ARG) && (kind == K_WAIT) && (&tgt_line) && (&tgt_cyc);
endmodule

// File: rtl/beam_list_engine_chk.sv
`timescale 1ns/1ps
module beam_list_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic wr_strobe,
    input logic halted
);
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    p_halt_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !frame_start) |=> halted);

    p_halt_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !wr_strobe);

    p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!halted && !wr_strobe));
endmodule

bind beam_list_engine beam_list_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .wr_strobe(wr_strobe), .halted(halted)
);

// File: tb/beam_list_engine_tb.sv
`timescale 1ns/1ps
module beam_list_engine_tb;
    localparam int AW    = 10;
    localparam int CPB   = 6;   // clocks per beam cycle
    localparam int NLINE = 8;
    localparam int NCYC  = 63;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [8:0] beam_line = '0;
    logic [5:0] beam_cycle = '0;
    logic [AW-1:0] ram_addr;
    logic [7:0] ram_data;
    logic       wr_strobe;
    logic [5:0] wr_reg;
    logic [7:0] wr_data;
    logic       halted;

    logic [7:0] mem [1<<AW];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [28:0] wlog [64];
    int wcnt = 0;

    // {line, cycle, reg, data}
    localparam logic [28:0] EXP_A [6] = '{
        {9'd2, 6'd5,  6'h20, 8'h01},
        {9'd2, 6'd6,  6'h20, 8'h00},
        {9'd3, 6'd10, 6'h21, 8'h07},
        {9'd3, 6'd13, 6'h21, 8'h07},
        {9'd3, 6'd16, 6'h21, 8'h07},
        {9'd3, 6'd20, 6'h23, 8'h55}
    };

    always #2 clk = ~clk;

    always @(posedge clk) ram_data <= mem[ram_addr];

    always @(posedge clk) begin
        #1;
        if (wr_strobe && wcnt < 64) begin
            wlog[wcnt] = {beam_line, beam_cycle, wr_reg, wr_data};
            wcnt++;
        end
    end

    beam_list_engine #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .beam_line(beam_line), .beam_cycle(beam_cycle),
        .ram_addr(ram_addr), .ram_data(ram_data),
        .wr_strobe(wr_strobe), .wr_reg(wr_reg), .wr_data(wr_data),
        .halted(halted)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame();
        wcnt = 0;
        for (int ln = 0; ln < NLINE; ln++) begin
            for (int cy = 0; cy < NCYC; cy++) begin
                @(negedge clk);
                beam_line  = 9'(ln);
                beam_cycle = 6'(cy);
                frame_start = (ln == 0 && cy == 0);
                @(negedge clk);
                frame_start = 1'b0;
                repeat (CPB - 2) @(negedge clk);
            end
        end
    endtask

    task automatic put(input int a, input logic [7:0] v);
        mem[a] = v;
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
        // Program A: waits, writes, counted loop, zero skips, end
        put(0, 8'h80); put(1, 8'h85);   // WAIT 2,5
        put(2, 8'h60); put(3, 8'h01);   // MOV 20,01
        put(4, 8'h60); put(5, 8'h00);   // MOV 20,00
        put(6, 8'h01); put(7, 8'h02);   // SETA 2
        put(8, 8'h80); put(9, 8'hCA);   // WAIT 3,10
        put(10, 8'h61); put(11, 8'h07); // MOV 21,07
        put(12, 8'h03);                 // DECA
        put(13, 8'h00); put(14, 8'hFB); // BRA -5 -> 10
        put(15, 8'h02); put(16, 8'h00); // SETB 0
        put(17, 8'h04);                 // DECB (zero: skip 18,19)
        put(18, 8'h62); put(19, 8'hEE); // MOV 22,EE skipped
        put(20, 8'h63); put(21, 8'h55); // MOV 23,55
        put(22, 8'hFF); put(23, 8'hFF); // END

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 strobe after reset", 32'(wr_strobe), 32'd0);
        check("R10 halted after reset", 32'(halted), 32'd0);

        run_frame();
        check("R2/R6 write count frame A", 32'(wcnt), 32'd6);
        for (int i = 0; i < 6; i++) begin
            // R1 R2 R4 R5 R6 R9: position, register and data of each write
            check("R1/R2/R4/R5/R6/R9 write entry", 32'(wlog[i]), 32'(EXP_A[i]));
        end
        check("R3 halted at end", 32'(halted), 32'd1);

        // Program B: restart, then a wait already passed
        put(0, 8'h64); put(1, 8'h11);   // MOV 24,11
        put(2, 8'h81); put(3, 8'h43);   // WAIT 5,3
        put(4, 8'h81); put(5, 8'h00);   // WAIT 4,0 (passed)
        put(6, 8'h64); put(7, 8'h99);   // MOV 24,99 never
        run_frame();
        check("R7/R8 write count frame B", 32'(wcnt), 32'd1);
        check("R7 restart write", 32'(wlog[0]), 32'({9'd0, 6'd0, 6'h24, 8'h11}));
        check("R8 halted low on passed wait", 32'(halted), 32'd0);

        // Program C: branch to itself
        put(0, 8'h00); put(1, 8'hFE);   // BRA -2
        put(2, 8'h65); put(3, 8'h01);   // MOV 25,01 never
        run_frame();
        check("R4 self loop writes", 32'(wcnt), 32'd0);
        check("R4 self loop not halted", 32'(halted), 32'd0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule